// File: doc/BRIEF.md
# Accumulator Machine Micro-Step Sequencer

This block is the control and datapath core of a small accumulator machine. A program counter, an instruction register, an accumulator, a B operand register, an address latch, a two-bit flag register and an adder all exchange values over one shared data bus. A sequencer issues one read strobe and one write strobe per clock. The read strobe names the unit that drives the bus, and the write strobe names the unit that captures it. When a step has a write strobe but no read strobe, the capturing unit takes the value held from the most recent driven step.

Every instruction begins with a one-cycle fetch. Three instructions then run fixed sequences of micro-steps: load, add and jump. Any other opcode returns straight to fetch. Program memory is outside the block and is read combinationally through the address and read-data ports.

Top module: `acc_cpu_seq`

## Requirements
- R1: While rst_ni is low, pc_o, acc_o and flags_o read zero. The first cycle after reset is a fetch.
- R2: A fetch lasts one cycle. It drives mem_addr_o with pc_o and sets rd_o bit 2 (memory), wr_o bit 1 (IR) and pc_inc_o. The PC then advances by one, wrapping modulo 16.
- R3: rd_o has at most one bit set in any cycle, and so does wr_o. Bit order for both is 0 PC, 1 IR, 2 memory, 3 ACC, 4 B, 5 adder, 6 address latch.
- R4: The instruction byte holds the opcode in bits 7:4 (1 load, 2 add, 3 jump) and the operand address in bits 3:0.
- R5: Load runs three steps after fetch. Step 1 is IR read with address-latch write. Step 2 is memory read with mem_addr_o equal to the operand. Step 3 is ACC write. ACC then holds the addressed byte.
- R6: Add runs four steps after fetch. Steps 1 and 2 match load, step 3 is B write, and step 4 is adder read with ACC write. ACC then holds the old ACC plus the addressed byte, modulo 256.
- R7: flags_o changes only at the end of the adder step. Bit 1 takes the carry out of the add and bit 0 is set when the 8-bit sum is zero.
- R8: Jump runs two steps after fetch. Step 1 is IR read with address-latch write, and step 2 is PC write. The PC then equals the operand.
- R9: An opcode other than 1, 2 or 3 has no execution steps. The next cycle is a fetch, the PC has advanced by one, and ACC and flags are unchanged.
- R10: ACC changes only at the end of an ACC-write step. PC changes only at a fetch or a PC-write step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_rdata_i | input | 8 | Byte returned by memory for mem_addr_o |
| mem_addr_o | output | 4 | Memory address bus |
| rd_o | output | 7 | Bus-driver strobes, one bit per unit |
| wr_o | output | 7 | Bus-capture strobes, one bit per unit |
| pc_inc_o | output | 1 | PC increment strobe |
| pc_o | output | 4 | Program counter |
| acc_o | output | 8 | Accumulator |
| flags_o | output | 2 | {carry, zero} from the last add |

## Verification
The properties assume that mem_rdata_i is a pure function of mem_addr_o within a cycle and that it does not change during a run. The bench models memory as a 16-byte array that is read combinationally. It fills the array only while reset is held, so every program it runs stays within these assumptions. Random opcodes cover the three instructions together with unused codes. A directed program covers an add that both carries and yields zero, a no-op, and a jump that wraps the PC.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;
  localparam int OPW   = 4;
  localparam int NUNIT = 7;
  localparam int U_PC  = 0;
  localparam int U_IR  = 1;
  localparam int U_MEM = 2;
  localparam int U_ACC = 3;
  localparam int U_B   = 4;
  localparam int U_ALU = 5;
  localparam int U_ADR = 6;
  localparam int STW   = 3;

  localparam logic [OPW-1:0] OP_LOAD = 4'h1;
  localparam logic [OPW-1:0] OP_ADD  = 4'h2;
  localparam logic [OPW-1:0] OP_JUMP = 4'h3;

  typedef logic [NUNIT-1:0] strobe_t;
  typedef logic [STW-1:0]   step_t;

  function automatic step_t last_step(logic [OPW-1:0] op);
    case (op)
      OP_LOAD: return step_t'(3);
      OP_ADD:  return step_t'(4);
      OP_JUMP: return step_t'(2);
      default: return step_t'(0);
    endcase
  endfunction
endpackage

// File: rtl/acc_seq_ctrl.sv
module acc_seq_ctrl
  import acc_seq_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [OPW-1:0] fetch_op_i,
  input  logic [OPW-1:0] ir_op_i,
  output strobe_t        rd_o,
  output strobe_t        wr_o,
  output logic           pc_inc_o,
  output logic           fetch_o
);
  step_t step_q, step_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_q <= '0;
    else         step_q <= step_d;
  end

  always_comb begin
    rd_o     = '0;
    wr_o     = '0;
    pc_inc_o = 1'b0;
    step_d   = '0;
    if (step_q == '0) begin
      rd_o[U_MEM] = 1'b1;
      wr_o[U_IR]  = 1'b1;
      pc_inc_o    = 1'b1;
      step_d      = (last_step(fetch_op_i) != '0) ? step_t'(1) : '0;
    end else begin
      step_d = (step_q == last_step(ir_op_i)) ? '0 : step_q + step_t'(1);
      case (step_q)
        step_t'(1): begin
          rd_o[U_IR]  = 1'b1;
          wr_o[U_ADR] = 1'b1;
        end
        step_t'(2): begin
          if (ir_op_i == OP_JUMP) wr_o[U_PC]  = 1'b1;
          else                    rd_o[U_MEM] = 1'b1;
        end
        step_t'(3): begin
          if (ir_op_i == OP_LOAD) wr_o[U_ACC] = 1'b1;
          else                    wr_o[U_B]   = 1'b1;
        end
        step_t'(4): begin
          rd_o[U_ALU] = 1'b1;
          wr_o[U_ACC] = 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign fetch_o = (step_q == '0);
endmodule

// File: rtl/acc_seq_alu.sv
module acc_seq_alu #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] sum_o,
  output logic          carry_o,
  output logic          zero_o
);
  logic [DW:0] full;
  assign full    = {1'b0, a_i} + {1'b0, b_i};
  assign sum_o   = full[DW-1:0];
  assign carry_o = full[DW];
  assign zero_o  = (full[DW-1:0] == '0);
endmodule

// File: rtl/acc_seq_datapath.sv
module acc_seq_datapath
  import acc_seq_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  strobe_t        rd_i,
  input  strobe_t        wr_i,
  input  logic           pc_inc_i,
  input  logic           fetch_i,
  input  logic [DW-1:0]  mem_rdata_i,
  output logic [AW-1:0]  mem_addr_o,
  output logic [AW-1:0]  pc_o,
  output logic [DW-1:0]  acc_o,
  output logic [1:0]     flags_o,
  output logic [OPW-1:0] ir_op_o
);
  logic [AW-1:0] pc_q, adr_q;
  logic [DW-1:0] ir_q, acc_q, b_q, hold_q;
  logic [1:0]    flags_q;
  logic [DW-1:0] drv, bus, sum;
  logic          carry, zero;

  acc_seq_alu #(.DW(DW)) u_alu (
    .a_i(acc_q), .b_i(b_q), .sum_o(sum), .carry_o(carry), .zero_o(zero)
  );

  // one-hot read strobes: OR of gated sources is the bus mux
  always_comb begin
    drv = '0;
    if (rd_i[U_PC])  drv = drv | DW'(pc_q);
    if (rd_i[U_IR])  drv = drv | ir_q;
    if (rd_i[U_MEM]) drv = drv | mem_rdata_i;
    if (rd_i[U_ACC]) drv = drv | acc_q;
    if (rd_i[U_B])   drv = drv | b_q;
    if (rd_i[U_ALU]) drv = drv | sum;
  end

  // undriven step: capture the value left by the last driven step
  assign bus = (rd_i != '0) ? drv : hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= '0;
      adr_q   <= '0;
      ir_q    <= '0;
      acc_q   <= '0;
      b_q     <= '0;
      hold_q  <= '0;
      flags_q <= '0;
    end else begin
      if (rd_i != '0)  hold_q <= drv;
      if (pc_inc_i)    pc_q   <= pc_q + AW'(1);
      else if (wr_i[U_PC]) pc_q <= bus[AW-1:0];
      if (wr_i[U_IR])  ir_q   <= bus;
      if (wr_i[U_ADR]) adr_q  <= bus[AW-1:0];
      if (wr_i[U_ACC]) acc_q  <= bus;
      if (wr_i[U_B])   b_q    <= bus;
      if (rd_i[U_ALU]) flags_q <= {carry, zero};
    end
  end

  assign mem_addr_o = fetch_i ? pc_q : adr_q;
  assign pc_o       = pc_q;
  assign acc_o      = acc_q;
  assign flags_o    = flags_q;
  assign ir_op_o    = ir_q[DW-1 -: OPW];
endmodule

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
  import acc_seq_pkg::*;
#(
  parameter int AW = 4,
  localparam int DW = AW + OPW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DW-1:0]     mem_rdata_i,
  output logic [AW-1:0]     mem_addr_o,
  output logic [NUNIT-1:0]  rd_o,
  output logic [NUNIT-1:0]  wr_o,
  output logic              pc_inc_o,
  output logic [AW-1:0]     pc_o,
  output logic [DW-1:0]     acc_o,
  output logic [1:0]        flags_o
);
  strobe_t        rd, wr;
  logic           pc_inc, fetch;
  logic [OPW-1:0] ir_op;

  acc_seq_ctrl u_ctrl (
    .clk_i, .rst_ni,
    .fetch_op_i(mem_rdata_i[DW-1 -: OPW]),
    .ir_op_i(ir_op),
    .rd_o(rd), .wr_o(wr), .pc_inc_o(pc_inc), .fetch_o(fetch)
  );

  acc_seq_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk_i, .rst_ni,
    .rd_i(rd), .wr_i(wr), .pc_inc_i(pc_inc), .fetch_i(fetch),
    .mem_rdata_i, .mem_addr_o, .pc_o, .acc_o, .flags_o,
    .ir_op_o(ir_op)
  );

  assign rd_o     = rd;
  assign wr_o     = wr;
  assign pc_inc_o = pc_inc;
endmodule

// File: rtl/acc_cpu_seq_chk.sv
module acc_cpu_seq_chk
  import acc_seq_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [AW-1:0]    mem_addr_o,
  input logic [NUNIT-1:0] rd_o,
  input logic [NUNIT-1:0] wr_o,
  input logic             pc_inc_o,
  input logic [AW-1:0]    pc_o,
  input logic [DW-1:0]    acc_o,
  input logic [1:0]       flags_o
);
  AST_RD_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rd_o)); // R3
  AST_WR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_o)); // R3
  AST_FETCH_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_inc_o |-> (mem_addr_o == pc_o) && rd_o[U_MEM] && wr_o[U_IR]); // R2
  AST_PC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_inc_o |=> pc_o == AW'($past(pc_o) + AW'(1))); // R2
  AST_PC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pc_inc_o && !wr_o[U_PC]) |=> $stable(pc_o)); // R10
  AST_ACC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_o[U_ACC] |=> $stable(acc_o)); // R10
  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_o[U_ALU] |=> $stable(flags_o)); // R7
  AST_ADD_TAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o[U_B] |=> rd_o[U_ALU] && wr_o[U_ACC]); // R6
  AST_JUMP_TAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o[U_PC] |=> pc_inc_o); // R8
endmodule

bind acc_cpu_seq acc_cpu_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mem_addr_o(mem_addr_o),
  .rd_o(rd_o), .wr_o(wr_o), .pc_inc_o(pc_inc_o), .pc_o(pc_o),
  .acc_o(acc_o), .flags_o(flags_o)
);

// File: tb/sim_acc_cpu_seq.sv
module sim_acc_cpu_seq;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] mem_rdata_i;
  logic [3:0] mem_addr_o;
  logic [6:0] rd_o, wr_o;
  logic       pc_inc_o;
  logic [3:0] pc_o;
  logic [7:0] acc_o;
  logic [1:0] flags_o;
  logic [7:0] mem [16];
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;
  assign mem_rdata_i = mem[mem_addr_o];

  acc_cpu_seq u0 (.*);

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int n_steps(logic [3:0] op);
    case (op) 4'h1: return 3; 4'h2: return 4; 4'h3: return 2; default: return 0; endcase
  endfunction

  // bits: 0 PC 1 IR 2 MEM 3 ACC 4 B 5 ALU 6 ADR
  function automatic logic [6:0] exp_rd(logic [3:0] op, int k);
    case (k)
      1: return 7'b0000010;
      2: return (op == 4'h3) ? 7'b0 : 7'b0000100;
      4: return 7'b0100000;
      default: return 7'b0;
    endcase
  endfunction

  function automatic logic [6:0] exp_wr(logic [3:0] op, int k);
    case (k)
      1: return 7'b1000000;
      2: return (op == 4'h3) ? 7'b0000001 : 7'b0;
      3: return (op == 4'h1) ? 7'b0001000 : 7'b0010000;
      4: return 7'b0001000;
      default: return 7'b0;
    endcase
  endfunction

  function automatic string op_tag(logic [3:0] op);
    case (op) 4'h1: return "R5"; 4'h2: return "R6"; 4'h3: return "R8"; default: return "R9"; endcase
  endfunction

  task automatic do_reset();
    rst_ni = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    chk(pc_o == 0, "R1 pc", pc_o, 0);
    chk(acc_o == 0, "R1 acc", acc_o, 0);
    chk(flags_o == 0, "R1 flags", flags_o, 0);
    rst_ni = 1'b1;
    #1;
    chk(pc_inc_o && rd_o == 7'b0000100 && wr_o == 7'b0000010, "R1 first fetch",
        {pc_inc_o, rd_o, wr_o}, {1'b1, 7'b0000100, 7'b0000010});
  endtask

  task automatic run_prog(int n);
    logic [3:0] mpc = 0;
    logic [7:0] macc = 0;
    logic [1:0] mfl = 0;
    for (int i = 0; i < n; i++) begin
      logic [7:0] ins;
      logic [3:0] op, a;
      logic [8:0] s;
      chk(pc_o == mpc, "R2 pc", pc_o, mpc);
      chk(acc_o == macc, "R10 acc", acc_o, macc);
      chk(flags_o == mfl, "R7 flags", flags_o, mfl);
      chk(pc_inc_o && rd_o == 7'b0000100 && wr_o == 7'b0000010 && mem_addr_o == mpc,
          "R2 fetch", {pc_inc_o, rd_o, wr_o, mem_addr_o}, {1'b1, 7'b0000100, 7'b0000010, mpc});
      ins = mem[mpc];
      op  = ins[7:4];
      a   = ins[3:0];
      mpc = mpc + 4'd1;
      for (int k = 1; k <= n_steps(op); k++) begin
        @(negedge clk_i);
        chk(rd_o == exp_rd(op, k) && $countones(rd_o) <= 1, {op_tag(op), " rd R3"}, rd_o, exp_rd(op, k));
        chk(wr_o == exp_wr(op, k), {op_tag(op), " wr R4"}, wr_o, exp_wr(op, k));
        chk(!pc_inc_o && pc_o == mpc && acc_o == macc, "R10 hold", {pc_inc_o, pc_o, acc_o}, {1'b0, mpc, macc});
        if (exp_rd(op, k) == 7'b0000100)
          chk(mem_addr_o == a, {op_tag(op), " addr"}, mem_addr_o, a);
      end
      case (op)
        4'h1: macc = mem[a];
        4'h2: begin
          s    = {1'b0, macc} + {1'b0, mem[a]};
          macc = s[7:0];
          mfl  = {s[8], s[7:0] == 8'h00};
        end
        4'h3: mpc = a;
        default: ;
      endcase
      @(negedge clk_i);
    end
  endtask

  task automatic fill_random();
    for (int j = 0; j < 16; j++) begin
      int sel = $urandom % 6;
      int v = $urandom % 13;
      logic [3:0] op;
      if (sel == 0)      op = (v == 0) ? 4'h0 : 4'(v + 3);
      else if (sel < 3)  op = 4'h2;
      else if (sel < 5)  op = 4'h1;
      else               op = 4'h3;
      mem[j] = {op, 4'($urandom)};
    end
  endtask

  initial begin
    void'($urandom(32'd7341));
    for (int j = 0; j < 16; j++) mem[j] = 8'h00;
    // directed: 0x80+0x80 -> carry and zero, no-op, jump and PC wrap
    mem[0] = 8'h1E; mem[1] = 8'h2F; mem[2] = 8'h00; mem[3] = 8'h3F;
    mem[14] = 8'h80; mem[15] = 8'h80;
    do_reset();
    run_prog(12);
    for (int p = 0; p < 5; p++) begin
      rst_ni = 1'b0;
      fill_random();
      do_reset();
      run_prog(300);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=0 exp=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule